// File: doc/BRIEF.md
# Tapped Delay Line with Power-Up Pattern

This block is a single-bit delay line of sixteen stages. On each rising clock edge with the shift enable high, a new data bit enters the first stage and every other stage takes the value of the stage before it. The output is not fixed to the last stage. A four-bit tap select picks any stage, so the delay can be set at run time from one to sixteen enabled edges.

There is no reset input. The stages start from a sixteen-bit parameter pattern, with bit i loaded into stage i. If the data input is tied to a constant and the tap is set to the last stage, the block gives out its preloaded pattern once and then settles at the constant. That makes it a counter-free source of fixed-length power-on reset pulses or delayed enables. With an arbitrary input it works as a variable delay line.

Top module: `tap_shift_line`

## Requirements
- R1: The line has 16 single-bit stages. With tap select 15, a bit that enters on an enabled edge appears at the output after the 16th enabled edge, counting its own edge.
- R2: On a rising edge with shift enable high, stage 0 takes the data input, and stage i takes the previous value of stage i-1 for i from 1 to 15.
- R3: While shift enable is low, rising edges leave every stage unchanged.
- R4: The output equals the stage whose index is the tap select value (bit 3 is the MSB). A change of tap select shows at the output in the same cycle, with no clock edge, whether or not shift enable is high.
- R5: Before the first enabled edge, stage i holds bit i of the INIT_PATTERN parameter. The parameter defaults to all zeros.
- R6: With INIT_PATTERN 16'hFF00, data input 0, tap 15 and enable held high, the output is high from start-up through the 7th enabled edge. It is low after the 8th enabled edge and stays low.
- R7: With INIT_PATTERN 16'h000F, data input 1, tap 15 and enable held high, the output is low from start-up through the 11th enabled edge. It is high after the 12th enabled edge and stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stages update on the rising edge |
| shift_en | input | 1 | High to shift on the next rising edge |
| din | input | 1 | Serial data entering stage 0 |
| tap_sel | input | 4 | Index of the stage driving the output |
| dout | output | 1 | Value of the selected stage |

## Verification
A stage change is due one rising edge after the enabled edge that causes it. A tap-select change is due at the output with no edge at all. The bench drives inputs on the falling edge and first compares the output half a cycle later, before the next rising edge. It then moves the tap again and compares a second time within the same low phase, which catches any output that waits for a clock. The reference queue advances only on rising edges where the enable was high. Start-up contents are read through every tap before the first edge. The pulse instances count enabled edges so that they can check the exact edge at which the output flips.

// File: rtl/tap_shift_pkg.sv
`timescale 1ns / 10ps
package tap_shift_pkg;
    localparam int unsigned TSL_DEFAULT_DEPTH = 16;
    localparam logic [TSL_DEFAULT_DEPTH-1:0] TSL_DEFAULT_PATTERN = '0;
endpackage

// File: rtl/tsl_stage_chain.sv
`timescale 1ns / 10ps
module tsl_stage_chain #(
    parameter int unsigned DEPTH = 16,
    parameter logic [DEPTH-1:0] INIT_PATTERN = '0
) (
    input  logic             clk,
    input  logic             shift_en,
    input  logic             din,
    output logic [DEPTH-1:0] stages
);
    typedef struct packed {
        logic [DEPTH-1:0] cells;
    } chain_state_t;

    chain_state_t state_d;
    chain_state_t state_q = '{cells: INIT_PATTERN};
    logic         armed_q = 1'b0;

    always_comb begin
        state_d = state_q;
        if (shift_en) begin
            state_d.cells = {state_q.cells[DEPTH-2:0], din};
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
        armed_q <= 1'b1;
    end

    assign stages = state_q.cells;

    assert_head_capture_R2: assert property (@(posedge clk) disable iff (!armed_q)
        shift_en |=> stages[0] == $past(din));

    assert_body_advance_R2: assert property (@(posedge clk) disable iff (!armed_q)
        shift_en |=> stages[DEPTH-1:1] == $past(stages[DEPTH-2:0]));

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!armed_q)
        !shift_en |=> $stable(stages));
endmodule

// File: rtl/tsl_tap_mux.sv
`timescale 1ns / 10ps
module tsl_tap_mux #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]  stages,
    input  logic [ADDR_W-1:0] tap_sel,
    output logic              dout
);
    logic [DEPTH-1:0] hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_tap
        assign hit[g] = (tap_sel == ADDR_W'(g)) & stages[g];
    end

    assign dout = |hit;
endmodule

// File: rtl/tap_shift_line.sv
`timescale 1ns / 10ps
module tap_shift_line #(
    parameter int unsigned DEPTH = tap_shift_pkg::TSL_DEFAULT_DEPTH,
    parameter logic [DEPTH-1:0] INIT_PATTERN = tap_shift_pkg::TSL_DEFAULT_PATTERN,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              shift_en,
    input  logic              din,
    input  logic [ADDR_W-1:0] tap_sel,
    output logic              dout
);
    logic [DEPTH-1:0] stages;
    logic             armed_q = 1'b0;

    tsl_stage_chain #(
        .DEPTH       (DEPTH),
        .INIT_PATTERN(INIT_PATTERN)
    ) i_chain (
        .clk     (clk),
        .shift_en(shift_en),
        .din     (din),
        .stages  (stages)
    );

    tsl_tap_mux #(
        .DEPTH(DEPTH)
    ) i_mux (
        .stages (stages),
        .tap_sel(tap_sel),
        .dout   (dout)
    );

    always_ff @(posedge clk) armed_q <= 1'b1;

    assert_first_tap_R2: assert property (@(posedge clk) disable iff (!armed_q)
        (shift_en && tap_sel == '0) |=> (tap_sel != '0) || (dout == $past(din)));

    assert_idle_output_R3: assert property (@(posedge clk) disable iff (!armed_q)
        !shift_en |=> !$stable(tap_sel) || $stable(dout));
endmodule

// File: tb/test_tap_shift_line.sv
`timescale 1ns / 10ps
module test_tap_shift_line;
    localparam logic [15:0] PAT_A = 16'h93A5;
    localparam logic [15:0] PAT_B = 16'hFF00;
    localparam logic [15:0] PAT_C = 16'h000F;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       en_a = 1'b0, din_a = 1'b0;
    logic [3:0] tap_a = 4'd0, tap_d = 4'd0;
    logic       en_bc = 1'b0;
    logic       dout_a, dout_b, dout_c, dout_d;

    int n_chk = 0;
    int n_bad = 0;
    int edges_bc = 0;
    bit mq[$];

    tap_shift_line #(.INIT_PATTERN(PAT_A)) i_tap_shift_line (
        .clk(clk), .shift_en(en_a), .din(din_a), .tap_sel(tap_a), .dout(dout_a));
    tap_shift_line #(.INIT_PATTERN(PAT_B)) i_pulse_hi (
        .clk(clk), .shift_en(en_bc), .din(1'b0), .tap_sel(4'd15), .dout(dout_b));
    tap_shift_line #(.INIT_PATTERN(PAT_C)) i_pulse_lo (
        .clk(clk), .shift_en(en_bc), .din(1'b1), .tap_sel(4'd15), .dout(dout_c));
    tap_shift_line i_dflt (
        .clk(clk), .shift_en(1'b0), .din(1'b1), .tap_sel(tap_d), .dout(dout_d));

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) mq.push_back(PAT_A[i]);
        // R5: start-up contents through every tap, before any edge
        for (int t = 0; t < 16; t++) begin
            tap_a = 4'(t);
            tap_d = 4'(t);
            #0.05;
            chk("R5 init pattern", dout_a, PAT_A[t]);
            chk("R5 default zero", dout_d, 1'b0);
        end
        chk("R6 start high", dout_b, 1'b1);
        chk("R7 start low", dout_c, 1'b0);
        en_bc = 1'b1;
        for (int cyc = 0; cyc < 400; cyc++) begin
            @(posedge clk);
            if (en_a) begin
                mq.push_front(din_a);
                void'(mq.pop_back());
            end
            if (en_bc) edges_bc++;
            @(negedge clk);
            // R3: long idle stretches between bursts
            if (cyc >= 100 && cyc < 140) en_a = 1'b0;
            else if (cyc < 20) en_a = 1'b1;
            else en_a = ($urandom_range(0, 9) < 7);
            din_a = 1'($urandom);
            tap_a = (cyc < 40) ? 4'd15 : 4'($urandom);
            #0.5;
            chk("R1/R2/R3 delay line", dout_a, mq[tap_a]);
            chk("R6 pulse", dout_b, (edges_bc < 8) ? 1'b1 : 1'b0);
            chk("R7 delayed enable", dout_c, (edges_bc >= 12) ? 1'b1 : 1'b0);
            // R4: tap change visible without a clock edge
            tap_a = 4'($urandom);
            #0.5;
            chk("R4 same-cycle tap", dout_a, mq[tap_a]);
        end
        finish_run();
    end
endmodule